// File: doc/BRIEF.md
# Port-Write Receive Controller

This block receives maintenance port-write packets from a link-side word stream and keeps exactly one of them in a local 16-word message buffer. Once a complete packet has been stored, the queue is full. Further packets are thrown away and recorded as discarded until software issues a clear-queue command. Software sees a mode register, a status register, two base-address registers and a read window onto the stored message, all on a simple single-cycle register port. A level interrupt tells software that a message is waiting or that a packet arrived with the wrong length.

Each packet arrives as a run of words with `lk_valid` high. The last word carries `lk_last`. A packet is accepted only when it has exactly the configured number of words. A short packet or an over-long packet sets the transaction-error flag instead, and the queue stays empty. The error flag can only be cleared while the unit is disabled, so the clearing sequence is disable, clear, re-enable. The base-address registers are frozen while the unit is enabled.

Top module: `pwr_rx_ctrl`

## Requirements
- R1: After reset, the mode register (address 0), the status register (address 1), the extended base (address 2), the base (address 3) and `irq` are all 0.
- R2: Mode bits read back at these positions: enable bit 0, error-interrupt enable bit 5, full-interrupt enable bit 8, snoop enable bit 20. The clear-queue command at bit 1 always reads as 0, and all other bits read as 0.
- R3: A 16-word packet received while the unit is enabled and the queue is empty sets the full level bit 20 and the full interrupt bit 4 of status. Word i of the packet can then be read at address 16+i.
- R4: Status bit 2 (busy) is 1 after the first word of an accepted packet and stays 1 until its last word is stored.
- R5: While the queue is full, an arriving packet sets status bit 3 (discarded) and leaves the stored message unchanged.
- R6: Writing the mode register with bit 1 set clears the full bit 20 from the next cycle on.
- R7: Writing 1 to status bit 4 or to status bit 3 clears that bit. Writing 1 to bit 20 has no effect on it.
- R8: A packet whose last word arrives before word 16 or after word 16 sets status bit 7 (transaction error) and does not fill the queue.
- R9: Writing 1 to status bit 7 clears it only while the enable bit is 0.
- R10: The base register (address 3) reads back with bits 5:0 as 0. The extended base (address 2) keeps its low 4 bits. Both ignore writes while the enable bit is 1.
- R11: `irq` is 1 exactly when (status bit 4 and mode bit 8) or (status bit 7 and mode bit 5).
- R12: A packet that begins while the unit is disabled is ignored entirely, including any of its words that arrive after the unit is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Link word valid |
| lk_data | input | 32 | Link payload word |
| lk_last | input | 1 | Marks the final word of a packet |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address; 16 and above is the message window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume a well-formed link stream: `lk_last` is high only together with `lk_valid`, and every packet ends with exactly one word marked last. They also assume that register writes touch one address per cycle. The stimulus always drives a complete packet with `lk_last` on its final word, leaves `lk_valid` low between packets, and changes inputs only on the falling clock edge. When a packet is split around a register access, the pause falls between two valid words and never inside a word. No packet arrives in the same cycle as a register write, so the properties on flag retention and address locking see isolated events.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int REG_W      = 32;
    localparam int BASE_ALIGN = 6;

    // mode register bit positions
    localparam int MODE_EN   = 0;
    localparam int MODE_CQ   = 1;
    localparam int MODE_EIE  = 5;
    localparam int MODE_QFIE = 8;
    localparam int MODE_SEN  = 20;

    // status register bit positions
    localparam int ST_BUSY = 2;
    localparam int ST_PWD  = 3;
    localparam int ST_QFI  = 4;
    localparam int ST_TE   = 7;
    localparam int ST_QF   = 20;

    // register word addresses (low half of the address space)
    localparam int A_MODE  = 0;
    localparam int A_STAT  = 1;
    localparam int A_EBASE = 2;
    localparam int A_BASE  = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_RECV,
        RX_DROP,
        RX_SKIP
    } rx_state_t;

    typedef struct packed {
        logic stored;
        logic bad_len;
        logic dropped;
    } rx_evt_t;

    typedef struct packed {
        logic sen;
        logic qfie;
        logic eie;
        logic en;
    } mode_t;

    typedef struct packed {
        logic qf;
        logic te;
        logic qfi;
        logic pwd;
    } stat_t;

    function automatic logic [REG_W-1:0] mode_word(mode_t m);
        logic [REG_W-1:0] w;
        w            = '0;
        w[MODE_EN]   = m.en;
        w[MODE_EIE]  = m.eie;
        w[MODE_QFIE] = m.qfie;
        w[MODE_SEN]  = m.sen;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] stat_word(stat_t s, logic busy);
        logic [REG_W-1:0] w;
        w          = '0;
        w[ST_BUSY] = busy;
        w[ST_PWD]  = s.pwd;
        w[ST_QFI]  = s.qfi;
        w[ST_TE]   = s.te;
        w[ST_QF]   = s.qf;
        return w;
    endfunction

endpackage

// File: rtl/pwr_link_rx.sv
module pwr_link_rx
    import pwr_pkg::*;
#(
    parameter int MSG_WORDS = 16,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(MSG_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              full,
    input  logic              lk_valid,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              lk_last,
    output logic              busy,
    output rx_evt_t           evt,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [DATA_W-1:0] buf_wd
);

    localparam int CNT_W = $clog2(MSG_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MSG_WORDS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MSG_WORDS - 1);

    rx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        evt     = '0;
        buf_we  = 1'b0;
        buf_idx = cnt_q[IDX_W-1:0];
        buf_wd  = lk_data;
        case (st_q)
            RX_IDLE: begin
                if (lk_valid) begin
                    if (!en) begin
                        if (!lk_last) st_d = RX_SKIP;
                    end else if (full) begin
                        evt.dropped = 1'b1;
                        if (!lk_last) st_d = RX_DROP;
                    end else begin
                        buf_we  = 1'b1;
                        buf_idx = '0;
                        if (lk_last) begin
                            evt.bad_len = 1'b1;
                            cnt_d       = '0;
                        end else begin
                            cnt_d = CNT_W'(1);
                            st_d  = RX_RECV;
                        end
                    end
                end
            end
            RX_RECV: begin
                if (lk_valid) begin
                    buf_we = (cnt_q < CNT_FULL);
                    if (lk_last) begin
                        st_d  = RX_IDLE;
                        cnt_d = '0;
                        if (cnt_q == CNT_LAST) evt.stored  = 1'b1;
                        else                   evt.bad_len = 1'b1;
                    end else if (cnt_q != CNT_FULL) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            RX_DROP, RX_SKIP: begin
                if (lk_valid && lk_last) st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign busy = (st_q == RX_RECV);

endmodule

// File: rtl/pwr_msg_buf.sv
module pwr_msg_buf #(
    parameter int MSG_WORDS = 16,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(MSG_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wd,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rd
);

    logic [DATA_W-1:0] words [MSG_WORDS];

    for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)                               word_q <= '0;
            else if (we && (widx == IDX_W'(g)))    word_q <= wd;
        end
        assign words[g] = word_q;
    end

    assign rd = words[ridx];

endmodule

// File: rtl/pwr_csr.sv
module pwr_csr
    import pwr_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wen,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    input  rx_evt_t               evt,
    input  logic                  busy,
    output mode_t                 mode,
    output stat_t                 stat,
    output logic [REG_W-1:BASE_ALIGN] base,
    output logic [EXT_W-1:0]      ebase,
    output logic [REG_W-1:0]      rdata,
    output logic                  irq
);

    mode_t                     mode_q;
    stat_t                     stat_q, stat_d;
    logic [REG_W-1:BASE_ALIGN] base_q;
    logic [EXT_W-1:0]          ebase_q;
    logic [REG_W-1:0]          w1c;
    logic                      hit_mode, hit_stat, hit_base, hit_ebase, cq_cmd;

    assign hit_mode  = wen && (addr == ADDR_W'(A_MODE));
    assign hit_stat  = wen && (addr == ADDR_W'(A_STAT));
    assign hit_base  = wen && (addr == ADDR_W'(A_BASE));
    assign hit_ebase = wen && (addr == ADDR_W'(A_EBASE));
    assign cq_cmd    = hit_mode && wdata[MODE_CQ];
    assign w1c       = hit_stat ? wdata : '0;

    // new events win over a simultaneous clear
    always_comb begin
        stat_d.pwd = (stat_q.pwd & ~w1c[ST_PWD]) | evt.dropped;
        stat_d.qfi = (stat_q.qfi & ~w1c[ST_QFI]) | evt.stored;
        stat_d.te  = (stat_q.te  & ~(w1c[ST_TE] & ~mode_q.en)) | evt.bad_len;
        stat_d.qf  = (stat_q.qf  & ~cq_cmd) | evt.stored;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            stat_q  <= '0;
            base_q  <= '0;
            ebase_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (hit_mode) begin
                mode_q.en   <= wdata[MODE_EN];
                mode_q.eie  <= wdata[MODE_EIE];
                mode_q.qfie <= wdata[MODE_QFIE];
                mode_q.sen  <= wdata[MODE_SEN];
            end
            if (hit_base && !mode_q.en)  base_q  <= wdata[REG_W-1:BASE_ALIGN];
            if (hit_ebase && !mode_q.en) ebase_q <= wdata[EXT_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(A_MODE):  rdata = mode_word(mode_q);
            ADDR_W'(A_STAT):  rdata = stat_word(stat_q, busy);
            ADDR_W'(A_EBASE): rdata = REG_W'(ebase_q);
            ADDR_W'(A_BASE):  rdata = {base_q, {BASE_ALIGN{1'b0}}};
            default:          rdata = '0;
        endcase
    end

    assign irq   = (stat_q.qfi & mode_q.qfie) | (stat_q.te & mode_q.eie);
    assign mode  = mode_q;
    assign stat  = stat_q;
    assign base  = base_q;
    assign ebase = ebase_q;

endmodule

// File: rtl/pwr_rx_ctrl.sv
module pwr_rx_ctrl
    import pwr_pkg::*;
#(
    parameter int MSG_WORDS = 16,
    parameter int EXT_W     = 4,
    parameter int ADDR_W    = $clog2(MSG_WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [REG_W-1:0]  lk_data,
    input  logic              lk_last,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    localparam int IDX_W = $clog2(MSG_WORDS);

    mode_t                     mode_w;
    stat_t                     stat_w;
    rx_evt_t                   evt_w;
    logic                      busy_w;
    logic                      buf_we_w;
    logic [IDX_W-1:0]          buf_idx_w;
    logic [REG_W-1:0]          buf_wd_w, buf_rd_w, csr_rd_w;
    logic [REG_W-1:BASE_ALIGN] base_w;
    logic [EXT_W-1:0]          ebase_w;

    pwr_link_rx #(
        .MSG_WORDS (MSG_WORDS),
        .DATA_W    (REG_W),
        .IDX_W     (IDX_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_w.en),
        .full     (stat_w.qf),
        .lk_valid (lk_valid),
        .lk_data  (lk_data),
        .lk_last  (lk_last),
        .busy     (busy_w),
        .evt      (evt_w),
        .buf_we   (buf_we_w),
        .buf_idx  (buf_idx_w),
        .buf_wd   (buf_wd_w)
    );

    pwr_msg_buf #(
        .MSG_WORDS (MSG_WORDS),
        .DATA_W    (REG_W),
        .IDX_W     (IDX_W)
    ) u_buf (
        .clk  (clk),
        .rst  (rst),
        .we   (buf_we_w),
        .widx (buf_idx_w),
        .wd   (buf_wd_w),
        .ridx (reg_addr[IDX_W-1:0]),
        .rd   (buf_rd_w)
    );

    pwr_csr #(
        .EXT_W  (EXT_W),
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk   (clk),
        .rst   (rst),
        .wen   (reg_wen),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .evt   (evt_w),
        .busy  (busy_w),
        .mode  (mode_w),
        .stat  (stat_w),
        .base  (base_w),
        .ebase (ebase_w),
        .rdata (csr_rd_w),
        .irq   (irq)
    );

    assign reg_rdata = reg_addr[ADDR_W-1] ? buf_rd_w : csr_rd_w;

endmodule

// File: rtl/pwr_rx_checker.sv
module pwr_rx_checker
    import pwr_pkg::*;
#(
    parameter int EXT_W  = 4,
    parameter int ADDR_W = 5
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      reg_wen,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [REG_W-1:0]          reg_wdata,
    input mode_t                     mode,
    input stat_t                     stat,
    input rx_evt_t                   evt,
    input logic                      busy,
    input logic                      buf_we,
    input logic [REG_W-1:BASE_ALIGN] base,
    input logic [EXT_W-1:0]          ebase
);

    // R3: the full level never rises without the full interrupt
    a_r3_full_flags: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.qf) |-> stat.qfi);

    // R4: a reception in progress implies the queue is empty
    a_r4_busy_empty: assert property (@(posedge clk) disable iff (rst)
        busy |-> !stat.qf);

    // R5: nothing is written into a full buffer
    a_r5_no_write_full: assert property (@(posedge clk) disable iff (rst)
        stat.qf |-> !buf_we);

    // R6: clear-queue command empties the entry in the next cycle
    a_r6_cq_empties: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == ADDR_W'(A_MODE) && reg_wdata[MODE_CQ] && !evt.stored)
        |=> !stat.qf);

    // R9: transaction error survives while enabled
    a_r9_te_hold: assert property (@(posedge clk) disable iff (rst)
        (stat.te && mode.en) |=> stat.te);

    // R10: base registers frozen while enabled
    a_r10_base_locked: assert property (@(posedge clk) disable iff (rst)
        mode.en |=> ($stable(base) && $stable(ebase)));

endmodule

bind pwr_rx_ctrl pwr_rx_checker #(
    .EXT_W  (EXT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode      (mode_w),
    .stat      (stat_w),
    .evt       (evt_w),
    .busy      (busy_w),
    .buf_we    (buf_we_w),
    .base      (base_w),
    .ebase     (ebase_w)
);

// File: tb/tb_pwr_rx_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_rx_ctrl;

    localparam logic [31:0] M_ON  = 32'h0010_0121;
    localparam logic [31:0] M_OFF = 32'h0010_0120;
    localparam logic [31:0] M_CQ  = 32'h0010_0123;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_data = '0;
    logic        lk_last = 1'b0;
    logic        reg_wen = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    pwr_rx_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_data   (lk_data),
        .lk_last   (lk_last),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp;
        bit          sel_irq;
        logic [4:0]  addr;
    } item_t;

    item_t exp_q[$];
    logic  chk_req = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic push_check(input logic [4:0] a, input logic [31:0] e,
                              input bit sel, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.tag = tag; it.exp = e; it.sel_irq = sel; it.addr = a;
        exp_q.push_back(it);
        chk_req = 1'b1;
        @(negedge clk);
        chk_req = 1'b0;
    endtask

    task automatic exp_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
        push_check(a, e, 1'b0, tag);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        push_check(5'd0, {31'b0, e}, 1'b1, tag);
    endtask

    task automatic send(input int first, input int cnt, input int total,
                        input logic [31:0] base);
        for (int i = first; i < first + cnt; i++) begin
            @(negedge clk);
            lk_valid = 1'b1;
            lk_data  = base + 32'(i);
            lk_last  = (i == total - 1);
        end
        @(negedge clk);
        lk_valid = 1'b0;
        lk_last  = 1'b0;
    endtask

    // monitor: compares each requested observation against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (chk_req && exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.sel_irq ? {31'b0, irq} : reg_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d actual=%08h expected=%08h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_reg(5'd0, 32'h0, "R1 mode");
        exp_reg(5'd1, 32'h0, "R1 status");
        exp_reg(5'd2, 32'h0, "R1 ebase");
        exp_reg(5'd3, 32'h0, "R1 base");
        exp_irq(1'b0, "R1 irq");

        // R10 base registers writable while disabled
        wr(5'd3, 32'h1234_5678);
        wr(5'd2, 32'h0000_0015);
        exp_reg(5'd3, 32'h1234_5640, "R10 base write disabled");
        exp_reg(5'd2, 32'h0000_0005, "R10 ebase write disabled");

        // R2 mode readback, command bit reads 0
        wr(5'd0, 32'hFFFF_FFFF);
        exp_reg(5'd0, M_ON, "R2 mode readback");

        // R10 locked while enabled
        wr(5'd3, 32'hFFFF_FFC0);
        wr(5'd2, 32'h0000_000A);
        exp_reg(5'd3, 32'h1234_5640, "R10 base locked");
        exp_reg(5'd2, 32'h0000_0005, "R10 ebase locked");

        // R4 busy mid packet, R3 stored packet
        send(0, 8, 16, 32'hA000_0000);
        exp_reg(5'd1, 32'h0000_0004, "R4 busy mid packet");
        send(8, 8, 16, 32'hA000_0000);
        exp_reg(5'd1, 32'h0010_0010, "R3 full after store");
        exp_irq(1'b1, "R11 irq on full");
        for (int i = 0; i < 16; i++)
            exp_reg(5'(16 + i), 32'hA000_0000 + 32'(i), "R3 message word");

        // R5 drop while full
        send(0, 16, 16, 32'hC000_0000);
        exp_reg(5'd1, 32'h0010_0018, "R5 discarded flag");
        exp_reg(5'd16, 32'hA000_0000, "R5 buffer word 0 kept");
        exp_reg(5'd31, 32'hA000_000F, "R5 buffer word 15 kept");

        // R7 write-one-to-clear
        wr(5'd1, 32'h0010_0010);
        exp_reg(5'd1, 32'h0010_0008, "R7 clear full interrupt");
        exp_irq(1'b0, "R11 irq after clear");
        wr(5'd1, 32'h0000_0008);
        exp_reg(5'd1, 32'h0010_0000, "R7 clear discarded");

        // R6 clear-queue command
        wr(5'd0, M_CQ);
        exp_reg(5'd1, 32'h0000_0000, "R6 queue emptied");
        exp_reg(5'd0, M_ON, "R2 command reads 0");

        // R3 second message after reopening
        send(0, 16, 16, 32'hB000_0000);
        exp_reg(5'd1, 32'h0010_0010, "R3 second store");
        exp_reg(5'd21, 32'hB000_0005, "R3 second word 5");
        wr(5'd1, 32'h0000_0010);
        wr(5'd0, M_CQ);
        exp_reg(5'd1, 32'h0000_0000, "R6 reopened");

        // R8 short packet
        send(0, 5, 5, 32'h9000_0000);
        exp_reg(5'd1, 32'h0000_0080, "R8 short packet error");
        exp_irq(1'b1, "R11 irq on error");

        // R9 clear only while disabled
        wr(5'd1, 32'h0000_0080);
        exp_reg(5'd1, 32'h0000_0080, "R9 no clear while enabled");
        wr(5'd0, M_OFF);
        wr(5'd1, 32'h0000_0080);
        exp_reg(5'd1, 32'h0000_0000, "R9 clear while disabled");
        wr(5'd0, M_ON);

        // R8 over-long packet
        send(0, 17, 17, 32'hE000_0000);
        exp_reg(5'd1, 32'h0000_0080, "R8 long packet error");
        wr(5'd0, M_OFF);
        wr(5'd1, 32'h0000_0080);
        exp_reg(5'd1, 32'h0000_0000, "R9 error cleared again");

        // R12 packet starting while disabled is ignored to its end
        send(0, 8, 16, 32'hD000_0000);
        wr(5'd0, 32'h0000_0001);
        send(8, 8, 16, 32'hD000_0000);
        exp_reg(5'd1, 32'h0000_0000, "R12 ignored packet");
        exp_reg(5'd16, 32'hE000_0000, "R12 buffer untouched");

        // R11 interrupt gated by enables
        send(0, 16, 16, 32'hF000_0000);
        exp_reg(5'd1, 32'h0010_0010, "R11 stored with irq masked");
        exp_irq(1'b0, "R11 irq masked");
        exp_reg(5'd16, 32'hF000_0000, "R3 word after reenable");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule